// File: doc/BRIEF.md
# JTAG test access port with boundary chain

This block is a boundary-scan test access port for a small programmable logic device. The test clock, mode select and serial data input drive a sixteen-state controller. That controller moves serial data through one of four paths: a 4-bit instruction register, a one-bit bypass register, a 32-bit identification register, or a boundary chain. The boundary chain has one cell per dedicated input pin and one cell per bidirectional pin. There is no separate test-reset pin. The controller enters its reset state only when a power-on reset is applied, or when the mode select is held high for five clocks.

Under the external-test instruction, the bidirectional pads are driven from the cells' update latches instead of from the core. Under the high-impedance instruction, every pad output enable is forced off. The other instructions leave the pads under core control. Serial output changes on the falling test-clock edge, and its enable is active only while a register is being shifted.

A configuration input turns the test port off. While it is low, the controller is held in reset and a status output tells the pin multiplexer that the four test pins belong to user I/O.

Top module: `jtag_tap_bscan`

## Requirements
- R1: While `por_n` is low the controller is in Test-Logic-Reset with IDCODE active, `tdo_oe` and `tdo` are 0, and the pads follow `core_out`/`core_oe`.
- R2: Five rising `tck` edges with `tms` high reach Test-Logic-Reset from any state. The next edge makes IDCODE the active instruction, which returns the pads to core control.
- R3: The instruction register is 4 bits wide and loads 4'b0001 in Capture-IR. It shifts with bit 0 nearest `tdo`. A new code takes effect on the rising edge that leaves Update-IR.
- R4: The codes are EXTEST=4'b0000, SAMPLE=4'b0001, IDCODE=4'b0010 and HIGHZ=4'b0011. BYPASS is 4'b1111, and every other code behaves as BYPASS.
- R5: Under IDCODE, Capture-DR loads `ID_VALUE` with bit 0 forced to 1. The value shifts out least significant bit first, followed by the bits entered on `tdi`.
- R6: Under BYPASS, Capture-DR loads 0, and each bit on `tdi` appears on `tdo` one shift later.
- R7: Under EXTEST or SAMPLE, the boundary chain is `N_IN+3*N_IO` bits long. Chain bit i (bit 0 nearest `tdo`) for i < N_IN captures `in_pad[i]`. For bidirectional pin k the chain bits are as follows: bit N_IN+3k captures `pad_in[k]`, bit N_IN+3k+1 captures `core_out[k]`, and bit N_IN+3k+2 captures `core_oe[k]`.
- R8: The per-pin data and enable update latches load from chain bits N_IN+3k+1 and N_IN+3k+2. They load only on the edge leaving Update-DR while EXTEST or SAMPLE is active. Under EXTEST, `pad_out`/`pad_oe` come from these latches.
- R9: `tdo` and `tdo_oe` change on falling `tck`. `tdo_oe` is 1 only in Shift-IR or Shift-DR, and otherwise `tdo` is 0.
- R10: Under HIGHZ every `pad_oe` bit is 0, `pad_out` follows `core_out`, and the bypass register is the selected path.
- R11: Under SAMPLE, IDCODE, BYPASS and the unused codes, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`.
- R12: While `jtag_en` is low, `test_pins_user` is 1, `tdo_oe` is 0 and the controller is held in Test-Logic-Reset. After the input returns high, IDCODE is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| jtag_en | input | 1 | Test port enabled (configuration) |
| tms | input | 1 | Test mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Drive enable for tdo |
| test_pins_user | output | 1 | The four test pins are released to user I/O |
| in_pad | input | N_IN | Values at the dedicated input pins |
| pad_in | input | N_IO | Values at the bidirectional pins |
| core_out | input | N_IO | Core output data for the bidirectional pins |
| core_oe | input | N_IO | Core output enables for the bidirectional pins |
| pad_out | output | N_IO | Output data to the bidirectional pads |
| pad_oe | output | N_IO | Output enables to the bidirectional pads |

## Verification
A controller state that has drifted from the reference shows at `tdo_oe` on the next falling edge. It can also show when a later instruction fails to reach the pads. A corrupted instruction register shows on the pad enables in the same cycle, because the pad multiplexer reads it without a register in between. A wrong capture source or chain order, or a bad identification bit, appears on `tdo` in the shift cycle that brings that bit to the end of the chain. An update latch loaded at the wrong time is visible on `pad_out`/`pad_oe` right away under EXTEST. In other modes it stays hidden until EXTEST is next selected.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET  = 4'h0,
        ST_IDLE   = 4'h1,
        ST_SEL_DR = 4'h2,
        ST_CAP_DR = 4'h3,
        ST_SHF_DR = 4'h4,
        ST_EX1_DR = 4'h5,
        ST_PAU_DR = 4'h6,
        ST_EX2_DR = 4'h7,
        ST_UPD_DR = 4'h8,
        ST_SEL_IR = 4'h9,
        ST_CAP_IR = 4'hA,
        ST_SHF_IR = 4'hB,
        ST_EX1_IR = 4'hC,
        ST_PAU_IR = 4'hD,
        ST_EX2_IR = 4'hE,
        ST_UPD_IR = 4'hF
    } tap_state_e;

    localparam int unsigned IR_W = 4;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0011;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef struct packed {
        logic sel_bsr;
        logic sel_id;
        logic sel_byp;
        logic drive_ext;
        logic force_hiz;
    } op_dec_t;

    function automatic tap_state_e tap_step(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            ST_RESET:  n = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SHF_IR;
            default:   n = tms ? ST_SEL_DR : ST_IDLE;
        endcase
        return n;
    endfunction

    function automatic op_dec_t op_decode(logic [IR_W-1:0] code);
        op_dec_t r;
        r = '0;
        case (code)
            OP_EXTEST: begin
                r.sel_bsr   = 1'b1;
                r.drive_ext = 1'b1;
            end
            OP_SAMPLE: r.sel_bsr = 1'b1;
            OP_IDCODE: r.sel_id  = 1'b1;
            OP_HIGHZ: begin
                r.sel_byp   = 1'b1;
                r.force_hiz = 1'b1;
            end
            default:   r.sel_byp = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       jtag_en,
    input  logic       tms,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (!jtag_en) begin
            fsm_d.st = ST_RESET;
        end else begin
            fsm_d.st = tap_step(fsm_q.st, tms);
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            fsm_q <= '{st: ST_RESET};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.st;

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic            ir_lsb,
    output logic [IR_W-1:0] op_code,
    output op_dec_t         dec
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] op;
    } ir_t;

    ir_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        case (state)
            ST_RESET:  ir_d.op = OP_IDCODE;
            ST_CAP_IR: ir_d.sh = IR_CAPTURE;
            ST_SHF_IR: ir_d.sh = {tdi, ir_q.sh[IR_W-1:1]};
            ST_UPD_IR: ir_d.op = ir_q.sh;
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            ir_q <= '{sh: '0, op: OP_IDCODE};
        end else begin
            ir_q <= ir_d;
        end
    end

    assign ir_lsb  = ir_q.sh[0];
    assign op_code = ir_q.op;
    assign dec     = op_decode(ir_q.op);

endmodule

// File: rtl/jtag_tap_bsr.sv
module jtag_tap_bsr
    import jtag_tap_pkg::*;
#(
    parameter int unsigned N_IN = 4,
    parameter int unsigned N_IO = 32
) (
    input  logic            tck,
    input  logic            por_n,
    input  tap_state_e      state,
    input  logic            sel,
    input  logic            drive_ext,
    input  logic            force_hiz,
    input  logic            tdi,
    input  logic [N_IN-1:0] in_pad,
    input  logic [N_IO-1:0] pad_in,
    input  logic [N_IO-1:0] core_out,
    input  logic [N_IO-1:0] core_oe,
    output logic            chain_lsb,
    output logic [N_IO-1:0] pad_out,
    output logic [N_IO-1:0] pad_oe,
    output logic [N_IO-1:0] upd_data,
    output logic [N_IO-1:0] upd_oe
);

    localparam int unsigned CELL_W  = 3;
    localparam int unsigned CHAIN_W = N_IN + CELL_W * N_IO;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
        logic [N_IO-1:0]    lat_d;
        logic [N_IO-1:0]    lat_e;
    } bsr_t;

    bsr_t               bsr_d, bsr_q;
    logic [CHAIN_W-1:0] cap_vec;

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in_cell
        assign cap_vec[gi] = in_pad[gi];
    end

    for (genvar gk = 0; gk < N_IO; gk++) begin : g_io_cell
        assign cap_vec[N_IN + CELL_W*gk + 0] = pad_in[gk];
        assign cap_vec[N_IN + CELL_W*gk + 1] = core_out[gk];
        assign cap_vec[N_IN + CELL_W*gk + 2] = core_oe[gk];

        assign pad_out[gk] = drive_ext ? bsr_q.lat_d[gk] : core_out[gk];
        assign pad_oe[gk]  = force_hiz ? 1'b0
                           : (drive_ext ? bsr_q.lat_e[gk] : core_oe[gk]);
    end

    always_comb begin
        bsr_d = bsr_q;
        if (sel) begin
            case (state)
                ST_CAP_DR: bsr_d.chain = cap_vec;
                ST_SHF_DR: bsr_d.chain = {tdi, bsr_q.chain[CHAIN_W-1:1]};
                ST_UPD_DR: begin
                    for (int k = 0; k < int'(N_IO); k++) begin
                        bsr_d.lat_d[k] = bsr_q.chain[int'(N_IN) + int'(CELL_W)*k + 1];
                        bsr_d.lat_e[k] = bsr_q.chain[int'(N_IN) + int'(CELL_W)*k + 2];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            bsr_q <= '0;
        end else begin
            bsr_q <= bsr_d;
        end
    end

    assign chain_lsb = bsr_q.chain[0];
    assign upd_data  = bsr_q.lat_d;
    assign upd_oe    = bsr_q.lat_e;

endmodule

// File: rtl/jtag_tap_bscan.sv
module jtag_tap_bscan
    import jtag_tap_pkg::*;
#(
    parameter int unsigned N_IN     = 4,
    parameter int unsigned N_IO     = 32,
    parameter logic [31:0] ID_VALUE = 32'h3C6A_91D4
) (
    input  logic            tck,
    input  logic            por_n,
    input  logic            jtag_en,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_oe,
    output logic            test_pins_user,
    input  logic [N_IN-1:0] in_pad,
    input  logic [N_IO-1:0] pad_in,
    input  logic [N_IO-1:0] core_out,
    input  logic [N_IO-1:0] core_oe,
    output logic [N_IO-1:0] pad_out,
    output logic [N_IO-1:0] pad_oe
);

    localparam int unsigned ID_W       = 32;
    localparam logic [ID_W-1:0] ID_CAP = ID_VALUE | 32'h1;

    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id;
    } dr_t;

    typedef struct packed {
        logic tdo;
        logic oe;
    } out_t;

    tap_state_e      tap_state;
    logic            ir_lsb;
    logic [IR_W-1:0] ir_code;
    op_dec_t         dec;
    logic            bsr_lsb;
    logic [N_IO-1:0] upd_data;
    logic [N_IO-1:0] upd_oe;

    dr_t  dr_d, dr_q;
    out_t out_d, out_q;

    jtag_tap_fsm u_fsm (
        .tck     (tck),
        .por_n   (por_n),
        .jtag_en (jtag_en),
        .tms     (tms),
        .state_o (tap_state)
    );

    jtag_tap_ir u_ir (
        .tck     (tck),
        .por_n   (por_n),
        .state   (tap_state),
        .tdi     (tdi),
        .ir_lsb  (ir_lsb),
        .op_code (ir_code),
        .dec     (dec)
    );

    jtag_tap_bsr #(
        .N_IN (N_IN),
        .N_IO (N_IO)
    ) u_bsr (
        .tck       (tck),
        .por_n     (por_n),
        .state     (tap_state),
        .sel       (dec.sel_bsr),
        .drive_ext (dec.drive_ext),
        .force_hiz (dec.force_hiz),
        .tdi       (tdi),
        .in_pad    (in_pad),
        .pad_in    (pad_in),
        .core_out  (core_out),
        .core_oe   (core_oe),
        .chain_lsb (bsr_lsb),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .upd_data  (upd_data),
        .upd_oe    (upd_oe)
    );

    // Bypass and identification data registers, rising edge
    always_comb begin
        dr_d = dr_q;
        case (tap_state)
            ST_CAP_DR: begin
                if (dec.sel_byp) dr_d.byp = 1'b0;
                if (dec.sel_id)  dr_d.id  = ID_CAP;
            end
            ST_SHF_DR: begin
                if (dec.sel_byp) dr_d.byp = tdi;
                if (dec.sel_id)  dr_d.id  = {tdi, dr_q.id[ID_W-1:1]};
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            dr_q <= '0;
        end else begin
            dr_q <= dr_d;
        end
    end

    // Serial output path, retimed to the falling edge
    always_comb begin
        out_d     = '0;
        out_d.oe  = (tap_state == ST_SHF_DR) || (tap_state == ST_SHF_IR);
        if (tap_state == ST_SHF_IR) begin
            out_d.tdo = ir_lsb;
        end else if (tap_state == ST_SHF_DR) begin
            if (dec.sel_bsr)     out_d.tdo = bsr_lsb;
            else if (dec.sel_id) out_d.tdo = dr_q.id[0];
            else                 out_d.tdo = dr_q.byp;
        end
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign tdo            = out_q.tdo;
    assign tdo_oe         = out_q.oe & jtag_en;
    assign test_pins_user = ~jtag_en;

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
    import jtag_tap_pkg::*;
#(
    parameter int unsigned N_IO = 32
) (
    input  logic            tck,
    input  logic            por_n,
    input  logic            jtag_en,
    input  logic            tms,
    input  logic            tdo_oe,
    input  tap_state_e      tap_state,
    input  logic [IR_W-1:0] ir_code,
    input  logic [N_IO-1:0] pad_oe,
    input  logic [N_IO-1:0] upd_data,
    input  logic [N_IO-1:0] upd_oe
);

    logic [2:0] tms_run_q;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            tms_run_q <= '0;
        end else if (!tms) begin
            tms_run_q <= '0;
        end else if (tms_run_q != 3'd5) begin
            tms_run_q <= tms_run_q + 3'd1;
        end
    end

    // R2: five high mode-select edges always end in reset
    assert_five_tms_R2: assert property (@(posedge tck) disable iff (!por_n)
        (tms_run_q == 3'd5) |-> (tap_state == ST_RESET));

    // R2: reset state restores IDCODE
    assert_reset_idcode_R2: assert property (@(posedge tck) disable iff (!por_n)
        (tap_state == ST_RESET) |=> (ir_code == OP_IDCODE));

    // R9: output drive only while shifting
    assert_tdo_quiet_R9: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe |-> ((tap_state == ST_SHF_DR) || (tap_state == ST_SHF_IR)));

    // R8: update latches move only when leaving Update-DR
    assert_latch_hold_R8: assert property (@(posedge tck) disable iff (!por_n)
        (tap_state != ST_UPD_DR) |=> ($stable(upd_data) && $stable(upd_oe)));

    // R10: high-impedance instruction disables every pad driver
    assert_hiz_R10: assert property (@(posedge tck) disable iff (!por_n)
        (ir_code == OP_HIGHZ) |-> (pad_oe == '0));

    // R12: a disabled port keeps the controller in reset
    assert_disabled_R12: assert property (@(posedge tck) disable iff (!por_n)
        !jtag_en |=> (tap_state == ST_RESET));

endmodule

bind jtag_tap_bscan jtag_tap_chk #(
    .N_IO (N_IO)
) u_chk (
    .tck       (tck),
    .por_n     (por_n),
    .jtag_en   (jtag_en),
    .tms       (tms),
    .tdo_oe    (tdo_oe),
    .tap_state (tap_state),
    .ir_code   (ir_code),
    .pad_oe    (pad_oe),
    .upd_data  (upd_data),
    .upd_oe    (upd_oe)
);

// File: tb/jtag_tap_bscan_bench.sv
module jtag_tap_bscan_bench;

    localparam int NI = 4;
    localparam int NO = 32;
    localparam int L  = NI + 3*NO;
    localparam logic [31:0] IDV = 32'h3C6A_91D4;

    // reference state numbering (bench-local)
    localparam int M_TLR = 0,  M_RTI = 1,  M_SDR = 2,  M_CDR = 3,  M_SHD = 4,
                   M_E1D = 5,  M_PD  = 6,  M_E2D = 7,  M_UDR = 8,  M_SIR = 9,
                   M_CIR = 10, M_SHI = 11, M_E1I = 12, M_PI  = 13, M_E2I = 14, M_UIR = 15;

    logic          tck = 1'b0;
    logic          por_n, jtag_en, tms, tdi;
    logic          tdo, tdo_oe, test_pins_user;
    logic [NI-1:0] in_pad;
    logic [NO-1:0] pad_in, core_out, core_oe, pad_out, pad_oe;

    int checks = 0;
    int errors = 0;

    // reference model state
    int         ms;
    logic [3:0] m_ir, m_irsh;
    bit         m_byp;
    bit         m_bs[$];
    bit         m_id[$];
    logic [NO-1:0] m_ud, m_ue;

    jtag_tap_bscan #(.N_IN(NI), .N_IO(NO), .ID_VALUE(IDV)) u_jtag_tap_bscan (
        .tck(tck), .por_n(por_n), .jtag_en(jtag_en), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe), .test_pins_user(test_pins_user),
        .in_pad(in_pad), .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #4 tck = ~tck;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic int m_next(int s, logic t);
        case (s)
            M_TLR: return t ? M_TLR : M_RTI;
            M_RTI: return t ? M_SDR : M_RTI;
            M_SDR: return t ? M_SIR : M_CDR;
            M_CDR: return t ? M_E1D : M_SHD;
            M_SHD: return t ? M_E1D : M_SHD;
            M_E1D: return t ? M_UDR : M_PD;
            M_PD:  return t ? M_E2D : M_PD;
            M_E2D: return t ? M_UDR : M_SHD;
            M_UDR: return t ? M_SDR : M_RTI;
            M_SIR: return t ? M_TLR : M_CIR;
            M_CIR: return t ? M_E1I : M_SHI;
            M_SHI: return t ? M_E1I : M_SHI;
            M_E1I: return t ? M_UIR : M_PI;
            M_PI:  return t ? M_E2I : M_PI;
            M_E2I: return t ? M_UIR : M_SHI;
            default: return t ? M_SDR : M_RTI;
        endcase
    endfunction

    // 0 = boundary, 1 = identification, 2 = bypass
    function automatic int m_path();
        if (m_ir == 4'b0000 || m_ir == 4'b0001) return 0;
        if (m_ir == 4'b0010) return 1;
        return 2;
    endfunction

    task automatic model_edge(input logic t, input logic d);
        logic [31:0] idc;
        idc = IDV | 32'h1;
        case (ms)
            M_TLR: m_ir = 4'b0010;
            M_CIR: m_irsh = 4'b0001;
            M_SHI: m_irsh = {d, m_irsh[3:1]};
            M_UIR: m_ir = m_irsh;
            M_CDR: begin
                if (m_path() == 0) begin
                    m_bs.delete();
                    for (int i = 0; i < NI; i++) m_bs.push_back(in_pad[i]);
                    for (int k = 0; k < NO; k++) begin
                        m_bs.push_back(pad_in[k]);
                        m_bs.push_back(core_out[k]);
                        m_bs.push_back(core_oe[k]);
                    end
                end else if (m_path() == 1) begin
                    m_id.delete();
                    for (int i = 0; i < 32; i++) m_id.push_back(idc[i]);
                end else begin
                    m_byp = 1'b0;
                end
            end
            M_SHD: begin
                if (m_path() == 0) begin
                    void'(m_bs.pop_front());
                    m_bs.push_back(d);
                end else if (m_path() == 1) begin
                    void'(m_id.pop_front());
                    m_id.push_back(d);
                end else begin
                    m_byp = d;
                end
            end
            M_UDR: begin
                if (m_path() == 0) begin
                    for (int k = 0; k < NO; k++) begin
                        m_ud[k] = m_bs[NI + 3*k + 1];
                        m_ue[k] = m_bs[NI + 3*k + 2];
                    end
                end
            end
            default: ;
        endcase
        ms = jtag_en ? m_next(ms, t) : M_TLR;
    endtask

    task automatic check_pads();
        string tag;
        logic [NO-1:0] eo, ee;
        if (!jtag_en)                tag = "R12";
        else if (m_ir == 4'b0000)    tag = "R8";
        else if (m_ir == 4'b0011)    tag = "R10";
        else if (m_ir == 4'b0001 || m_ir == 4'b0010 || m_ir == 4'b1111) tag = "R11";
        else                         tag = "R4";
        if (m_ir == 4'b0000) begin
            eo = m_ud; ee = m_ue;
        end else if (m_ir == 4'b0011) begin
            eo = core_out; ee = '0;
        end else begin
            eo = core_out; ee = core_oe;
        end
        chk(tag, 64'(pad_out), 64'(eo));
        chk(tag, 64'(pad_oe), 64'(ee));
        chk("R12", 64'(test_pins_user), 64'(!jtag_en));
    endtask

    task automatic check_tdo();
        string tag;
        logic eb, eoe;
        eb = 1'b0;
        tag = "R9";
        if (ms == M_SHI) begin
            eb = m_irsh[0]; tag = "R3";
        end else if (ms == M_SHD) begin
            if (m_path() == 0)      begin eb = m_bs[0]; tag = "R7"; end
            else if (m_path() == 1) begin eb = m_id[0]; tag = "R5"; end
            else begin
                eb = m_byp;
                if (m_ir == 4'b0011)      tag = "R10";
                else if (m_ir == 4'b1111) tag = "R6";
                else                      tag = "R4";
            end
        end
        eoe = ((ms == M_SHI) || (ms == M_SHD)) && jtag_en;
        chk(tag, 64'(tdo), 64'(eb));
        chk("R9", 64'(tdo_oe), 64'(eoe));
    endtask

    task automatic tick(input logic t, input logic d);
        tms = t;
        tdi = d;
        @(posedge tck);
        model_edge(t, d);
        #1;
        check_pads();
        @(negedge tck);
        #1;
        check_tdo();
    endtask

    task automatic load_ir(input logic [3:0] code);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) tick(i == 3, code[i]);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic scan_dr(input int n, input logic [127:0] data);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        for (int i = 0; i < n; i++) tick(i == n - 1, data[i]);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    function automatic logic [NO-1:0] lat_bits(input logic [127:0] p, input int off);
        logic [NO-1:0] r;
        for (int k = 0; k < NO; k++) r[k] = p[NI + 3*k + off];
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge tck);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] p1, p2;
        p1 = {32'h0000_000C, 32'h9B3E_55F0, 32'h1E2D_B4C7, 32'h6A98_E31F};
        p2 = {32'h0000_0007, 32'h24C1_AA0F, 32'hE1D2_4B38, 32'h9567_1CE0};
        por_n = 1'b0; jtag_en = 1'b1; tms = 1'b1; tdi = 1'b0;
        in_pad = 4'b1010; pad_in = 32'hDEAD_0F5A;
        core_out = 32'h1234_5678; core_oe = 32'hFFFF_0000;
        ms = M_TLR; m_ir = 4'b0010; m_irsh = 4'b0000; m_byp = 1'b0;
        m_ud = '0; m_ue = '0;
        for (int i = 0; i < L; i++)  m_bs.push_back(1'b0);
        for (int i = 0; i < 32; i++) m_id.push_back(1'b0);

        repeat (3) @(negedge tck);
        #1;
        // R1: reset state at the ports
        chk("R1", 64'(tdo_oe), 64'd0);
        chk("R1", 64'(tdo), 64'd0);
        chk("R1", 64'(pad_oe), 64'(core_oe));
        chk("R1", 64'(pad_out), 64'(core_out));
        por_n = 1'b1;

        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        // R5: identification value, then tdi bits follow
        scan_dr(40, 128'h00_A5C3_0F0F);

        // R3 capture pattern while loading SAMPLE; R7 capture of pins
        load_ir(4'b0001);
        scan_dr(L, p1);
        chk("R8", 64'(pad_out), 64'(core_out));
        chk("R8", 64'(pad_oe), 64'(core_oe));

        // R8: EXTEST drives preloaded latches
        load_ir(4'b0000);
        chk("R8", 64'(pad_out), 64'(lat_bits(p1, 1)));
        chk("R8", 64'(pad_oe), 64'(lat_bits(p1, 2)));
        core_out = 32'h0F0F_F0F0; core_oe = 32'h3333_CCCC;
        pad_in = 32'h5A5A_1234; in_pad = 4'b0110;
        scan_dr(L, p2);
        chk("R8", 64'(pad_out), 64'(lat_bits(p2, 1)));
        chk("R8", 64'(pad_oe), 64'(lat_bits(p2, 2)));

        // R10: HIGHZ
        load_ir(4'b0011);
        chk("R10", 64'(pad_oe), 64'd0);
        scan_dr(8, 128'hA5);

        // R6: BYPASS
        load_ir(4'b1111);
        scan_dr(10, 128'h2D3);

        // R4: unused codes act as BYPASS
        load_ir(4'b0101);
        chk("R4", 64'(pad_oe), 64'(core_oe));
        scan_dr(6, 128'h2B);
        load_ir(4'b1000);
        scan_dr(5, 128'h13);

        // R7 with a second pin pattern
        pad_in = 32'h8001_7FFE; in_pad = 4'b1001;
        load_ir(4'b0001);
        scan_dr(L, p1);

        // R2: five high TMS from Shift-DR under EXTEST
        load_ir(4'b0000);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b0);
        repeat (5) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        chk("R2", 64'(pad_oe), 64'(core_oe));
        chk("R2", 64'(pad_out), 64'(core_out));
        scan_dr(32, 128'h0);

        // R2: five high TMS from Shift-IR
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        repeat (5) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        scan_dr(32, 128'h0);

        // R12: port disabled
        load_ir(4'b1111);
        jtag_en = 1'b0;
        for (int i = 0; i < 12; i++) tick(((i * 7) % 3) == 0, i[0]);
        chk("R12", 64'(tdo_oe), 64'd0);
        chk("R12", 64'(test_pins_user), 64'd1);
        jtag_en = 1'b1;
        tick(1'b0, 1'b0);
        chk("R12", 64'(test_pins_user), 64'd0);
        scan_dr(32, 128'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule